// File: doc/BRIEF.md
# Debug Breakpoint Match Unit

This block holds four debug breakpoint slots for a processor core. Each slot has an address register; a shared control word gives each slot an enable, a match kind and an access length. On every cycle marked by the check strobe, execution slots compare their address against the current instruction pointer. Data-watch slots take a per-slot hit strobe from the memory stage, which does the actual address snooping outside this block.

When a check runs, the block can rewrite the low slot bits of the debug status word and can raise a one-cycle debug exception request. Hit bits are recorded for every slot that matched, enabled or not. The status word is written back only when an enabled slot hit or when the caller forces the update. The exception is raised only for enabled hits. Software loads the address, control and status registers through a single-cycle write port.

Top module: `dbg_bkpt_unit`

## Requirements
- R1: After reset all slot addresses are zero, `status_o` reads 0xFFFF0FF0, `ctrl_o` reads 0x00000400 and `exc_o` is low.
- R2: A write with `wr_sel_i` 0..3 loads that slot's address, 4 loads control as `wr_data_i | 0x00000400`, and 5 loads status as `wr_data_i | 0xFFFF0FF0`. Each takes effect at the clock edge. Selects 6 and 7 change nothing.
- R3: Slot n is enabled when control bit 2n or bit 2n+1 is set. Its kind is control bits [17+4n:16+4n]. Its length field, bits [19+4n:18+4n], is stored but does not affect matching.
- R4: A slot of kind 0 (execute) hits during a check when its address equals `pc_i`.
- R5: A slot of kind 1 (data write) or kind 3 (data read/write) hits when `wp_hit_i[n]` is high during a check. A slot of kind 2 (I/O) never hits.
- R6: A status update clears status bits [3:0], sets bit n for every hitting slot whether or not it is enabled, and keeps bits [31:4].
- R7: The status update happens only when at least one enabled slot hits or `force_upd_i` is high. Otherwise status is unchanged.
- R8: `exc_o` is high for exactly the cycle after a check in which an enabled slot hit. A forced update with no enabled hit leaves it low.
- R9: A check uses register values from before the edge: a same-cycle address write does not affect that check, and a status update wins over a same-cycle status write.
- R10: Without `chk_i`, neither `pc_i` nor `wp_hit_i` affects status or `exc_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Write target: 0..3 slot address, 4 control, 5 status |
| wr_data_i | input | 32 | Write data |
| chk_i | input | 1 | Run a breakpoint check this cycle |
| pc_i | input | 32 | Current instruction pointer |
| wp_hit_i | input | 4 | Per-slot data-watch hit strobes |
| force_upd_i | input | 1 | Force the status update on this check |
| status_o | output | 32 | Debug status register |
| ctrl_o | output | 32 | Debug control register |
| exc_o | output | 1 | Debug exception request |

## Verification
Register writes and a check's status result are both registered at the same edge, so they are visible one cycle after the stimulus. `exc_o` comes from the same edge and falls one cycle later unless another enabled hit is checked. The bench applies each stimulus on the falling edge and samples 1 ns after the following rising edge. It then samples once more a cycle later to confirm that the exception pulse has ended and that idle cycles left status alone. Same-cycle write and check cases are driven in a single cycle, so the ordering rule is observed directly at the ports.

// File: rtl/dbg_bkpt_pkg.sv
package dbg_bkpt_pkg;
  typedef enum logic [1:0] {
    SK_EXEC  = 2'd0,
    SK_WRITE = 2'd1,
    SK_IO    = 2'd2,
    SK_RDWR  = 2'd3
  } slot_kind_e;

  localparam logic [31:0] STAT_FIX1 = 32'hFFFF_0FF0;
  localparam logic [31:0] CTRL_FIX1 = 32'h0000_0400;
  localparam logic [2:0]  SEL_CTRL  = 3'd4;
  localparam logic [2:0]  SEL_STAT  = 3'd5;
  localparam int          KIND_LSB  = 16;
  localparam int          FLD_STEP  = 4;

  function automatic logic slot_en(input logic [31:0] ctrl, input int n);
    return ctrl[2*n] | ctrl[2*n+1];
  endfunction

  function automatic slot_kind_e slot_kind(input logic [31:0] ctrl, input int n);
    return slot_kind_e'(ctrl[KIND_LSB+FLD_STEP*n +: 2]);
  endfunction
endpackage

// File: rtl/dbg_slot_match.sv
module dbg_slot_match
  import dbg_bkpt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  slot_kind_e        kind_i,
  input  logic              wp_i,
  output logic              hit_o
);
  always_comb begin
    unique case (kind_i)
      SK_EXEC:          hit_o = (addr_i == pc_i);
      SK_WRITE, SK_RDWR: hit_o = wp_i;
      default:          hit_o = 1'b0; // I/O slots are unsupported
    endcase
  end
endmodule

// File: rtl/dbg_status_upd.sv
module dbg_status_upd #(
  parameter int SLOTS = 4,
  parameter int REG_W = 32
) (
  input  logic             chk_i,
  input  logic             force_i,
  input  logic [SLOTS-1:0] hit_i,
  input  logic [SLOTS-1:0] en_i,
  input  logic [REG_W-1:0] status_q_i,
  output logic             upd_o,
  output logic [REG_W-1:0] status_d_o,
  output logic             exc_d_o
);
  logic any_en_hit;

  assign any_en_hit = |(hit_i & en_i);
  assign upd_o      = chk_i & (any_en_hit | force_i);
  assign status_d_o = {status_q_i[REG_W-1:SLOTS], hit_i};
  assign exc_d_o    = chk_i & any_en_hit;
endmodule

// File: rtl/dbg_bkpt_unit.sv
module dbg_bkpt_unit
  import dbg_bkpt_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int REG_W = 32,
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             chk_i,
  input  logic [REG_W-1:0] pc_i,
  input  logic [SLOTS-1:0] wp_hit_i,
  input  logic             force_upd_i,
  output logic [REG_W-1:0] status_o,
  output logic [REG_W-1:0] ctrl_o,
  output logic             exc_o
);
  logic [REG_W-1:0] addr_q [SLOTS];
  logic [REG_W-1:0] ctrl_q, status_q, status_d;
  logic [SLOTS-1:0] hit, en;
  logic             upd, exc_d;

  for (genvar gi = 0; gi < SLOTS; gi++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      addr_q[gi] <= '0;
      else if (wr_en_i && wr_sel_i == SEL_W'(gi))       addr_q[gi] <= wr_data_i;
    end

    assign en[gi] = slot_en(ctrl_q, gi);

    dbg_slot_match #(.ADDR_W(REG_W)) u_match (
      .addr_i (addr_q[gi]),
      .pc_i   (pc_i),
      .kind_i (slot_kind(ctrl_q, gi)),
      .wp_i   (wp_hit_i[gi]),
      .hit_o  (hit[gi])
    );
  end

  dbg_status_upd #(.SLOTS(SLOTS), .REG_W(REG_W)) u_upd (
    .chk_i      (chk_i),
    .force_i    (force_upd_i),
    .hit_i      (hit),
    .en_i       (en),
    .status_q_i (status_q),
    .upd_o      (upd),
    .status_d_o (status_d),
    .exc_d_o    (exc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= CTRL_FIX1;
      status_q <= STAT_FIX1;
      exc_o    <= 1'b0;
    end else begin
      exc_o <= exc_d;
      if (wr_en_i && wr_sel_i == SEL_CTRL) ctrl_q <= wr_data_i | CTRL_FIX1;
      // hardware update outranks a software status write
      if (upd)                                  status_q <= status_d;
      else if (wr_en_i && wr_sel_i == SEL_STAT) status_q <= wr_data_i | STAT_FIX1;
    end
  end

  assign status_o = status_q;
  assign ctrl_o   = ctrl_q;
endmodule

// File: rtl/dbg_bkpt_unit_chk.sv
module dbg_bkpt_unit_chk
  import dbg_bkpt_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [2:0]  wr_sel_i,
  input logic        chk_i,
  input logic        force_upd_i,
  input logic [31:0] status_o,
  input logic [31:0] ctrl_o,
  input logic        exc_o
);
  a_r1_status_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o & STAT_FIX1) == STAT_FIX1);

  a_r10_idle_status_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chk_i && !(wr_en_i && wr_sel_i == SEL_STAT)) |=> $stable(status_o));

  a_r8_exc_needs_check: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chk_i |=> !exc_o);

  a_r6_exc_has_hit_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> (status_o[3:0] != 4'h0));

  a_r5_io_slot_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_i && force_upd_i && ctrl_o[17:16] == 2'b10) |=> !status_o[0]);
endmodule

bind dbg_bkpt_unit dbg_bkpt_unit_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_sel_i    (wr_sel_i),
  .chk_i       (chk_i),
  .force_upd_i (force_upd_i),
  .status_o    (status_o),
  .ctrl_o      (ctrl_o),
  .exc_o       (exc_o)
);

// File: tb/dbg_bkpt_unit_tb.sv
`timescale 1ns/1ps
module dbg_bkpt_unit_tb;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        wr_en_i = 1'b0, chk_i = 1'b0, force_upd_i = 1'b0;
  logic [2:0]  wr_sel_i = '0;
  logic [31:0] wr_data_i = '0, pc_i = '0;
  logic [3:0]  wp_hit_i = '0;
  logic [31:0] status_o, ctrl_o;
  logic        exc_o;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  localparam logic [31:0] SFIX = 32'hFFFF_0FF0;

  always #2 clk_i = ~clk_i;

  dbg_bkpt_unit u_dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one cycle at the falling edge, sample 1 ns after the rising edge
  task automatic step(input logic we, input logic [2:0] sel, input logic [31:0] d,
                      input logic chk, input logic [31:0] pc, input logic [3:0] wp,
                      input logic frc);
    @(negedge clk_i);
    wr_en_i = we; wr_sel_i = sel; wr_data_i = d;
    chk_i = chk; pc_i = pc; wp_hit_i = wp; force_upd_i = frc;
    @(posedge clk_i); #1;
    @(negedge clk_i);
    wr_en_i = 0; chk_i = 0; force_upd_i = 0; wp_hit_i = '0;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    step(1, sel, d, 0, 32'h0, 4'h0, 0);
  endtask

  task automatic t_reset;
    check("R1 status", status_o, SFIX);
    check("R1 ctrl", ctrl_o, 32'h400);
    check("R1 exc", {31'h0, exc_o}, 0);
    // addresses reset to zero: all exec slots hit pc 0
    wr(4, 32'h1);
    step(0, 0, 0, 1, 32'h0, 4'h0, 0);
    check("R1/R4/R6 all-zero addr hit", status_o, SFIX | 32'hF);
    check("R8 exc on enabled hit", {31'h0, exc_o}, 1);
    @(posedge clk_i); #1;
    check("R8 exc one cycle", {31'h0, exc_o}, 0);
  endtask

  task automatic t_exec;
    wr(1, 32'h1000);
    wr(4, 32'h8); // slot1 enabled via odd bit
    check("R2/R3 ctrl write", ctrl_o, 32'h408);
    step(0, 0, 0, 1, 32'h1000, 4'h0, 0);
    check("R4/R6 exec slot1", status_o, SFIX | 32'h2);
    check("R3 odd enable bit", {31'h0, exc_o}, 1);
    step(0, 0, 0, 1, 32'h0, 4'h0, 0);
    check("R7 disabled hits no update", status_o, SFIX | 32'h2);
    check("R7 no exc", {31'h0, exc_o}, 0);
    step(0, 0, 0, 1, 32'h0, 4'h0, 1);
    check("R6 forced records disabled hits", status_o, SFIX | 32'hD);
    check("R8 forced no exc", {31'h0, exc_o}, 0);
  endtask

  task automatic t_watch;
    wr(4, 32'h0231_0015);
    step(0, 0, 0, 1, 32'h5555, 4'b0111, 0);
    check("R5 write and rdwr watch", status_o, SFIX | 32'h3);
    check("R5 exc", {31'h0, exc_o}, 1);
    step(0, 0, 0, 1, 32'h5555, 4'b0100, 1);
    check("R5 io never hits", status_o, SFIX);
    check("R5 io no exc", {31'h0, exc_o}, 0);
    wr(4, 32'h02F1_0015); // length bits on slot 1
    step(0, 0, 0, 1, 32'h5555, 4'b0010, 0);
    check("R3 length ignored", status_o, SFIX | 32'h2);
    check("R3 length exc", {31'h0, exc_o}, 1);
    step(0, 0, 0, 0, 32'h0, 4'b1111, 1);
    check("R10 no check no update", status_o, SFIX | 32'h2);
    check("R10 no exc", {31'h0, exc_o}, 0);
  endtask

  task automatic t_regs;
    wr(5, 32'h0);
    check("R2 status write", status_o, SFIX);
    wr(4, 32'h0);
    check("R2 ctrl write", ctrl_o, 32'h400);
    wr(6, 32'h1234_5678);
    wr(7, 32'hFFFF_FFFF);
    check("R2 sel6/7 ctrl", ctrl_o, 32'h400);
    check("R2 sel6/7 status", status_o, SFIX);
  endtask

  task automatic t_order;
    wr(0, 32'h40);
    wr(4, 32'h1);
    step(1, 0, 32'h80, 1, 32'h80, 4'h0, 0);
    check("R9 old addr used", {31'h0, exc_o}, 0);
    step(0, 0, 0, 1, 32'h80, 4'h0, 0);
    check("R9 new addr next", {31'h0, exc_o}, 1);
    step(1, 5, 32'h0000_0F00, 1, 32'h80, 4'h0, 0);
    check("R9 update beats write", status_o, SFIX | 32'h1);
  endtask

  initial begin
    fork
      begin
        #10 rst_ni = 1'b1;
        @(negedge clk_i); #0.5;
        t_reset(); t_exec(); t_watch(); t_regs(); t_order();
        done = 1'b1;
      end
      begin
        repeat (20000) @(posedge clk_i);
        if (!done) begin
          n_chk++; n_err++;
          $display("FAIL watchdog: actual=hung expected=done");
        end
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule